// File: doc/BRIEF.md
# FSK Tape Record Decoder

This block turns the digitised output of a tape comparator back into bytes. The input is a square wave whose full-cycle length carries the information. The block times the interval from one rising transition to the next in clock counts, and it works through a record in three stages. It first hunts for a steady leader tone. After it has locked on, it waits for the one short cycle that ends the leader. It then reads every following full cycle as a data bit.

A long cycle is a 1 and a short cycle is a 0. A single threshold separates the two, so a recorder that runs somewhat fast or slow still decodes correctly. Bits are packed most significant first. Each finished byte is presented for one clock together with a flag that stays high for as long as a record is being read. There is no error check: every byte is delivered exactly as it was decoded. A long silence on the input ends the record, and the block then goes back to hunting for a leader. An enable input holds the block in leader search while it is low.

Top module: `tape_fsk_decoder`

## Requirements
- R1: While `rstN` is low, `byteValid` and `recordActive` are 0.
- R2: A leader is locked only after `LOCK_COUNT` consecutive full cycles, each with a period (clock cycles from one rising input edge to the next) in the band from `LEADER_MIN` to `LEADER_MAX` inclusive. One cycle fewer gives no record and no bytes.
- R3: Any measured cycle outside the leader band, met while hunting for a leader, sets the consecutive count back to zero.
- R4: Once the leader is locked, further leader-band cycles keep the block waiting. The first cycle shorter than `LEADER_MIN` is taken as the sync cycle: it raises `recordActive` and is not decoded as a data bit.
- R5: Inside a record, a cycle whose period is at least `BIT_THRESH` decodes as 1 and a shorter cycle decodes as 0. This holds for periods that have drifted away from their nominal values.
- R6: Bits are shifted in most significant bit first. After 8 bits, `byteData` carries the byte and `byteValid` is high for exactly one clock, always while `recordActive` is high.
- R7: When the input shows no transition for `TIMEOUT` clocks, `recordActive` drops, any partial byte is thrown away and leader search restarts. The first rising edge after that only starts the timing of the next cycle.
- R8: While `enable` is low, the block stays in leader search, with `recordActive` and `byteValid` held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Decoding allowed when high |
| tapeIn | input | 1 | Comparator output, asynchronous |
| byteValid | output | 1 | One-clock strobe marking a new byte |
| byteData | output | BYTE_W | Decoded byte, first bit received in the MSB |
| recordActive | output | 1 | High from the sync cycle to the end of the record |

## Verification
A rising transition on `tapeIn` passes through two synchroniser stages and one edge register. Every decision the transition triggers therefore becomes visible after the third clock edge that follows it: the byte strobe for the cycle that ends the eighth bit, and the raising of `recordActive` for the cycle that ends the sync. The drop of `recordActive` comes `TIMEOUT` edges after that, measured from the last transition. The bench drives the input only on falling clock edges, and its monitor compares each one-clock byte strobe against the scoreboard at the falling edge. The flag checks are placed well inside the stable windows, so none of them depends on the exact edge within the latency.

// File: rtl/tape_fsk_pkg.sv
package tape_fsk_pkg;

  typedef enum logic [1:0] {
    ST_SEEK = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2
  } dec_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;
    logic shiftEn;
    logic bitVal;
  } dp_ctrl_t;

endpackage

// File: rtl/tape_fsk_datapath.sv
module tape_fsk_datapath
  import tape_fsk_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int TIMEOUT     = 2000,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tapeIn,
  input  dp_ctrl_t          ctrl,
  output logic              cycleStrobe,
  output logic [CNT_W-1:0]  period,
  output logic              timeoutHit,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData
);

  localparam int BIT_CNT_W = $clog2(BYTE_W);
  localparam int IDLE_W    = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0]     CNT_MAX    = '1;
  localparam logic [IDLE_W-1:0]    IDLE_LIMIT = IDLE_W'(TIMEOUT);
  localparam logic [IDLE_W-1:0]    IDLE_LAST  = IDLE_W'(TIMEOUT - 1);
  localparam logic [BIT_CNT_W-1:0] BIT_LAST   = BIT_CNT_W'(BYTE_W - 1);

  // synchroniser stages plus one stage that remembers the previous level
  logic [SYNC_STAGES:0] syncPipe;
  logic syncLvl, prevLvl, riseDet, anyEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[SYNC_STAGES-1:0], tapeIn};
  end

  assign syncLvl = syncPipe[SYNC_STAGES-1];
  assign prevLvl = syncPipe[SYNC_STAGES];
  assign riseDet = syncLvl & ~prevLvl;
  assign anyEdge = syncLvl ^ prevLvl;

  // full-cycle period counter, restarted at each rising edge
  logic [CNT_W-1:0] periodCnt;
  logic             havePrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt <= '0;
      havePrev  <= 1'b0;
    end else begin
      if (riseDet)                periodCnt <= '0;
      else if (periodCnt != CNT_MAX) periodCnt <= periodCnt + 1'b1;
      if (ctrl.restart)  havePrev <= 1'b0;
      else if (riseDet)  havePrev <= 1'b1;
    end
  end

  assign period      = (periodCnt == CNT_MAX) ? CNT_MAX : periodCnt + 1'b1;
  assign cycleStrobe = riseDet & havePrev;

  // silence detector on both edges
  logic [IDLE_W-1:0] idleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     idleCnt <= '0;
    else if (anyEdge)              idleCnt <= '0;
    else if (idleCnt != IDLE_LIMIT) idleCnt <= idleCnt + 1'b1;
  end

  assign timeoutHit = !anyEdge && (idleCnt == IDLE_LAST);

  // byte assembly, first bit lands in the MSB
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0]    shiftReg;
  logic [BYTE_W-1:0]    shiftNext;

  assign shiftNext = {shiftReg[BYTE_W-2:0], ctrl.bitVal};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      shiftReg  <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
    end else begin
      byteValid <= 1'b0;
      if (ctrl.restart) begin
        bitCnt <= '0;
      end else if (ctrl.shiftEn) begin
        shiftReg <= shiftNext;
        if (bitCnt == BIT_LAST) begin
          bitCnt    <= '0;
          byteValid <= 1'b1;
          byteData  <= shiftNext;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tape_fsk_control.sv
module tape_fsk_control
  import tape_fsk_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int LEADER_MIN = 1100,
  parameter int LEADER_MAX = 1500,
  parameter int BIT_THRESH = 750,
  parameter int LOCK_COUNT = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cycleStrobe,
  input  logic [CNT_W-1:0] period,
  input  logic             timeoutHit,
  output dp_ctrl_t         ctrl,
  output logic             recordActive
);

  localparam int RUN_W = $clog2(LOCK_COUNT + 1);
  localparam logic [CNT_W-1:0] BAND_LO  = CNT_W'(LEADER_MIN);
  localparam logic [CNT_W-1:0] BAND_HI  = CNT_W'(LEADER_MAX);
  localparam logic [CNT_W-1:0] ONE_MIN  = CNT_W'(BIT_THRESH);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_COUNT - 1);

  dec_state_e       state;
  logic [RUN_W-1:0] runCnt;
  logic             inBand, isShort, restart;

  assign inBand  = (period >= BAND_LO) && (period <= BAND_HI);
  assign isShort = (period < BAND_LO);
  assign restart = !enable || timeoutHit;

  assign ctrl.restart = restart;
  assign ctrl.shiftEn = (state == ST_DATA) && cycleStrobe && !restart;
  assign ctrl.bitVal  = (period >= ONE_MIN);
  assign recordActive = (state == ST_DATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_SEEK;
      runCnt <= '0;
    end else if (restart) begin
      state  <= ST_SEEK;
      runCnt <= '0;
    end else if (cycleStrobe) begin
      unique case (state)
        ST_SEEK: begin
          if (!inBand) begin
            runCnt <= '0;
          end else if (runCnt == RUN_LAST) begin
            runCnt <= '0;
            state  <= ST_SYNC;
          end else begin
            runCnt <= runCnt + 1'b1;
          end
        end
        ST_SYNC: begin
          if (isShort)      state <= ST_DATA;
          else if (!inBand) state <= ST_SEEK;
        end
        ST_DATA: state <= ST_DATA;
        default: state <= ST_SEEK;
      endcase
    end
  end

endmodule

// File: rtl/tape_fsk_decoder.sv
module tape_fsk_decoder
  import tape_fsk_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int LEADER_MIN = 1100,
  parameter int LEADER_MAX = 1500,
  parameter int BIT_THRESH = 750,
  parameter int LOCK_COUNT = 64,
  parameter int TIMEOUT    = 2000,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              tapeIn,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData,
  output logic              recordActive
);

  dp_ctrl_t         ctrl;
  logic             cycleStrobe;
  logic             timeoutHit;
  logic [CNT_W-1:0] period;

  tape_fsk_datapath #(
    .CNT_W(CNT_W), .TIMEOUT(TIMEOUT), .BYTE_W(BYTE_W), .SYNC_STAGES(2)
  ) dp (
    .clk(clk), .rstN(rstN), .tapeIn(tapeIn), .ctrl(ctrl),
    .cycleStrobe(cycleStrobe), .period(period), .timeoutHit(timeoutHit),
    .byteValid(byteValid), .byteData(byteData)
  );

  tape_fsk_control #(
    .CNT_W(CNT_W), .LEADER_MIN(LEADER_MIN), .LEADER_MAX(LEADER_MAX),
    .BIT_THRESH(BIT_THRESH), .LOCK_COUNT(LOCK_COUNT)
  ) ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .cycleStrobe(cycleStrobe),
    .period(period), .timeoutHit(timeoutHit), .ctrl(ctrl),
    .recordActive(recordActive)
  );

endmodule

// File: rtl/tape_fsk_decoder_chk.sv
module tape_fsk_decoder_chk #(
  parameter int TIMEOUT = 2000,
  parameter int BYTE_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              tapeIn,
  input logic              byteValid,
  input logic [BYTE_W-1:0] byteData,
  input logic              recordActive
);

  // quiet window counted on the raw input, margin covers the sync latency
  localparam int QUIET_LIMIT = TIMEOUT + 3;
  localparam int Q_W = $clog2(QUIET_LIMIT + 1);
  localparam logic [Q_W-1:0] Q_MAX = Q_W'(QUIET_LIMIT);

  logic [Q_W-1:0] quietCnt;
  logic           lastIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quietCnt <= '0;
      lastIn   <= 1'b0;
    end else begin
      lastIn <= tapeIn;
      if (tapeIn != lastIn)   quietCnt <= '0;
      else if (quietCnt != Q_MAX) quietCnt <= quietCnt + 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |-> (!byteValid && !recordActive));

  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  assert_strobe_in_record_R6: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> recordActive);

  assert_silence_ends_record_R7: assert property (@(posedge clk) disable iff (!rstN)
    (quietCnt == Q_MAX) |-> !recordActive);

  assert_disable_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!recordActive && !byteValid));

  logic unusedData;
  assign unusedData = ^byteData;

endmodule

bind tape_fsk_decoder tape_fsk_decoder_chk #(.TIMEOUT(TIMEOUT), .BYTE_W(BYTE_W)) chkInst (
  .clk(clk), .rstN(rstN), .enable(enable), .tapeIn(tapeIn),
  .byteValid(byteValid), .byteData(byteData), .recordActive(recordActive)
);

// File: tb/tape_fsk_decoder_test.sv
module tape_fsk_decoder_test;

  localparam int CNT_W      = 8;
  localparam int LEADER_MIN = 36;
  localparam int LEADER_MAX = 46;
  localparam int BIT_THRESH = 24;
  localparam int LOCK_COUNT = 8;
  localparam int TIMEOUT    = 60;
  localparam int BYTE_W     = 8;

  localparam int P_LEAD = 40;
  localparam int P_SYNC = 12;
  localparam int P_ONE  = 32;
  localparam int P_ZERO = 16;

  logic clk = 1'b0;
  logic rstN;
  logic enable;
  logic tapeIn;
  logic byteValid;
  logic [BYTE_W-1:0] byteData;
  logic recordActive;

  int checkCount = 0;
  int errorCount = 0;
  bit finished = 1'b0;

  logic [BYTE_W-1:0] expData[$];
  string             expReq[$];

  always #2 clk = ~clk;  // 250 MHz

  tape_fsk_decoder #(
    .CNT_W(CNT_W), .LEADER_MIN(LEADER_MIN), .LEADER_MAX(LEADER_MAX),
    .BIT_THRESH(BIT_THRESH), .LOCK_COUNT(LOCK_COUNT), .TIMEOUT(TIMEOUT),
    .BYTE_W(BYTE_W)
  ) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .tapeIn(tapeIn),
    .byteValid(byteValid), .byteData(byteData), .recordActive(recordActive)
  );

  task automatic checkBit(input string req, input logic act, input logic exp);
    checkCount++;
    if (act !== exp) begin
      errorCount++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  // one full cycle: rises are exactly p clocks apart
  task automatic tapeCycle(input int p);
    tapeIn = 1'b1;
    repeat (p / 2) @(negedge clk);
    tapeIn = 1'b0;
    repeat (p - p / 2) @(negedge clk);
  endtask

  task automatic leader(input int n, input int p);
    for (int i = 0; i < n; i++) tapeCycle(p);
  endtask

  task automatic sendByte(input logic [7:0] b, input int oneP, input int zeroP,
                          input bit push, input string req);
    if (push) begin
      expData.push_back(b);
      expReq.push_back(req);
    end
    for (int i = 7; i >= 0; i--) tapeCycle(b[i] ? oneP : zeroP);
  endtask

  // a closing rise, then silence long enough to end the record
  task automatic finishRecord();
    tapeIn = 1'b1;
    repeat (TIMEOUT + 20) @(negedge clk);
    tapeIn = 1'b0;
    repeat (TIMEOUT + 20) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN === 1'b1 && byteValid === 1'b1) begin
      checkCount++;
      if (expData.size() == 0) begin
        errorCount++;
        $display("FAIL R6 unexpected byte actual %02h expected none", byteData);
      end else begin
        automatic logic [7:0] e = expData.pop_front();
        automatic string r = expReq.pop_front();
        if (byteData !== e) begin
          errorCount++;
          $display("FAIL %s byte actual %02h expected %02h", r, byteData, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errorCount++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checkCount, errorCount);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; tapeIn = 1'b0;
    repeat (3) @(negedge clk);
    checkBit("R1 byteValid in reset", byteValid, 1'b0);
    checkBit("R1 recordActive in reset", recordActive, 1'b0);
    rstN = 1'b1; enable = 1'b1;
    repeat (5) @(negedge clk);

    // R2 exact lock count, R4 sync, R5/R6 nominal bytes
    leader(LOCK_COUNT, P_LEAD);
    tapeCycle(P_SYNC);
    sendByte(8'hA5, P_ONE, P_ZERO, 1'b1, "R6");
    checkBit("R4 recordActive after sync", recordActive, 1'b1);
    sendByte(8'h3C, P_ONE, P_ZERO, 1'b1, "R5");
    finishRecord();
    checkBit("R7 recordActive after silence", recordActive, 1'b0);

    // R5 drifted speed, R4 long leader keeps waiting
    leader(12, 37);
    tapeCycle(10);
    sendByte(8'hFF, 28, 20, 1'b1, "R5");
    sendByte(8'h00, 28, 20, 1'b1, "R5");
    sendByte(8'h81, 28, 20, 1'b1, "R5");
    checkBit("R4 recordActive drift record", recordActive, 1'b1);
    finishRecord();

    // R2 one leader cycle short
    leader(LOCK_COUNT - 1, P_LEAD);
    tapeCycle(P_SYNC);
    sendByte(8'hA5, P_ONE, P_ZERO, 1'b0, "R2");
    checkBit("R2 no lock with short leader", recordActive, 1'b0);
    finishRecord();

    // R3 out-of-band cycle splits the leader run
    leader(5, P_LEAD);
    tapeCycle(60);
    leader(5, P_LEAD);
    tapeCycle(P_SYNC);
    sendByte(8'h96, P_ONE, P_ZERO, 1'b0, "R3");
    checkBit("R3 no lock with split leader", recordActive, 1'b0);
    finishRecord();

    // R7 partial byte dropped on silence
    leader(LOCK_COUNT, P_LEAD);
    tapeCycle(P_SYNC);
    tapeCycle(P_ONE); tapeCycle(P_ZERO); tapeCycle(P_ONE); tapeCycle(P_ZERO);
    checkBit("R7 recordActive during partial byte", recordActive, 1'b1);
    finishRecord();
    checkBit("R7 recordActive after partial byte", recordActive, 1'b0);
    leader(LOCK_COUNT, P_LEAD);
    tapeCycle(P_SYNC);
    sendByte(8'h5A, P_ONE, P_ZERO, 1'b1, "R7");
    finishRecord();

    // R8 disabled decoder ignores a full record
    enable = 1'b0;
    leader(10, P_LEAD);
    tapeCycle(P_SYNC);
    sendByte(8'hE7, P_ONE, P_ZERO, 1'b0, "R8");
    checkBit("R8 recordActive while disabled", recordActive, 1'b0);
    finishRecord();
    enable = 1'b1;
    repeat (4) @(negedge clk);
    leader(LOCK_COUNT, P_LEAD);
    tapeCycle(P_SYNC);
    sendByte(8'hC3, P_ONE, P_ZERO, 1'b1, "R8");
    finishRecord();

    repeat (20) @(negedge clk);
    checkCount++;
    if (expData.size() != 0) begin
      errorCount++;
      $display("FAIL R6 missing bytes actual %0d pending expected 0", expData.size());
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checkCount, errorCount);
    $finish;
  end

endmodule